// File: doc/BRIEF.md
# SCL Low Timeout Monitor

This block watches the clock line of a two-wire system management bus and measures how long that line stays low without a break. It runs on the system clock. A prescaler turns the system clock into millisecond ticks. A saturating counter then accumulates the whole milliseconds of the current low period. When the line has been low for more than 25 ms, the block declares a timeout. It does not wait before acting: in that same cycle it issues a one-cycle abort request so that the local bus controller can reset its communication, which is far sooner than the 10 ms the bus rules allow. The block cannot free a line that another device holds low, so all it does is report the condition and ask for the local reset.

A sticky status bit records that a timeout happened. It stays set until software clears it with a write-one-to-clear pulse. An enable input switches the whole check on or off. While the enable is low, nothing is measured. The incoming line is asynchronous, so it passes through a two-flop synchronizer before any counting takes place.

Top module: `scl_low_tmo_mon`

## Requirements
- R1: After reset, low_ms_o is 0 and tmo_o, abort_o and sts_o are all 0.
- R2: With en_i high, let scl_i be driven low just before rising edge k and held low. Then abort_o, tmo_o and sts_o rise after edge k+1+26*CLKS_PER_MS. This is the tick that completes millisecond LIMIT_MS+1 (26 with the default limit).
- R3: low_ms_o counts the whole milliseconds of the current low period. It goes up by one every CLKS_PER_MS enabled low cycles and holds at LIMIT_MS+1 instead of wrapping.
- R4: A high level on scl_i clears the millisecond count, even if it is sampled on only one edge. Driven high before edge m, it brings low_ms_o and tmo_o to 0 after edge m+2. The next low period then starts timing from zero.
- R5: tmo_o stays high for as long as scl_i stays low and en_i stays high after a timeout.
- R6: abort_o is a single-cycle pulse. It fires exactly once per low period, no matter how much longer the line stays low.
- R7: sts_o is set in the cycle abort_o fires. It stays set until it is cleared, even after the line returns high.
- R8: A one-cycle high on sts_clr_i clears sts_o after the next edge. If a timeout is detected in that same cycle, the set wins and sts_o stays 1.
- R9: While en_i is low, low_ms_o is held at 0 and no timeout or abort happens. Dropping en_i before edge d clears tmo_o after edge d.
- R10: Raising en_i before edge e while scl_i is already low starts the measurement from that point. The abort then follows after edge e-1+26*CLKS_PER_MS.
- R11: A low period of 26*CLKS_PER_MS-1 sampled cycles reaches a count of 25 but causes no timeout, no abort and no status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enables the low-time check |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sts_clr_i | input | 1 | Write-one-to-clear pulse for the sticky status |
| low_ms_o | output | $clog2(LIMIT_MS+2) | Whole milliseconds of the current low period, saturating |
| tmo_o | output | 1 | Timeout level while the low period lasts |
| abort_o | output | 1 | One-cycle request to reset local bus logic |
| sts_o | output | 1 | Sticky timeout status |

## Verification
Every result has a latency that is known from the register chain. The synchronizer adds two edges, so an abort is due exactly 2+26*CLKS_PER_MS cycles after the line is driven low. An abort after enabling mid-low is due 26*CLKS_PER_MS cycles after the enable. A clear caused by the line going high appears three cycles after the rise, and a clear caused by disabling appears one cycle after the drop. The driver computes each abort cycle from these figures and queues it. The monitor compares every abort it sees against the head of that queue, using a free-running cycle count, so an abort that comes early, comes late or repeats is reported. All level checks wait for a named cycle and sample on the falling clock edge, the cycle before and the cycle of each expected change.

// File: rtl/scl_tmo_pkg.sv
package scl_tmo_pkg;
  localparam int unsigned DEF_CLKS_PER_MS = 100_000;
  localparam int unsigned DEF_LIMIT_MS    = 25;
  localparam int unsigned SYNC_STAGES     = 2;

  function automatic int unsigned cnt_width(input int unsigned max_val);
    return (max_val > 1) ? $clog2(max_val + 1) : 1;
  endfunction
endpackage

// File: rtl/scl_tmo_sync.sv
module scl_tmo_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/scl_tmo_prescale.sv
module scl_tmo_prescale #(
  parameter int unsigned CLKS_PER_MS = 100_000,
  localparam int unsigned PRE_W = scl_tmo_pkg::cnt_width(CLKS_PER_MS - 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic             wrap;

  assign wrap   = (pre_q == PRE_W'(CLKS_PER_MS - 1));
  assign tick_o = run_i && wrap;

  // restart the phase on every break so each tick is a full ms of low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (!run_i) pre_q <= '0;
    else if (wrap)   pre_q <= '0;
    else             pre_q <= pre_q + 1'b1;
  end

  p_pre_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_q <= PRE_W'(CLKS_PER_MS - 1));
  p_pre_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> pre_q == '0);
endmodule

// File: rtl/scl_tmo_timer.sv
module scl_tmo_timer #(
  parameter int unsigned LIMIT_MS = 25,
  localparam int unsigned MS_W = $clog2(LIMIT_MS + 2)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            tick_i,
  output logic [MS_W-1:0] ms_o,
  output logic            sat_o,
  output logic            hit_o
);
  localparam logic [MS_W-1:0] SAT_VAL = MS_W'(LIMIT_MS + 1);

  logic [MS_W-1:0] ms_q;

  assign sat_o = (ms_q == SAT_VAL);
  assign hit_o = run_i && tick_i && (ms_q == MS_W'(LIMIT_MS));
  assign ms_o  = ms_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ms_q <= '0;
    else if (!run_i)            ms_q <= '0;
    else if (tick_i && !sat_o)  ms_q <= ms_q + 1'b1;
  end

  p_ms_sat_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ms_q <= SAT_VAL);
  p_ms_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> ms_q == '0);
  p_ms_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !tick_i |=> ms_q == $past(ms_q));
endmodule

// File: rtl/scl_tmo_status.sv
module scl_tmo_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic clr_i,
  output logic abort_o,
  output logic sts_o
);
  logic abort_q, sts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      abort_q <= 1'b0;
      sts_q   <= 1'b0;
    end else begin
      abort_q <= hit_i;
      sts_q   <= hit_i | (sts_q & ~clr_i);  // set beats clear
    end
  end

  assign abort_o = abort_q;
  assign sts_o   = sts_q;

  p_abort_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_q |=> !abort_q);
  p_abort_sets_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_q |-> sts_q);
  p_sticky_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_q && !clr_i |=> sts_q);
  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !hit_i |=> !sts_q);
endmodule

// File: rtl/scl_low_tmo_mon.sv
module scl_low_tmo_mon #(
  parameter int unsigned CLKS_PER_MS = scl_tmo_pkg::DEF_CLKS_PER_MS,
  parameter int unsigned LIMIT_MS    = scl_tmo_pkg::DEF_LIMIT_MS,
  localparam int unsigned MS_W       = $clog2(LIMIT_MS + 2)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            scl_i,
  input  logic            sts_clr_i,
  output logic [MS_W-1:0] low_ms_o,
  output logic            tmo_o,
  output logic            abort_o,
  output logic            sts_o
);
  logic scl_s, run, tick, hit;

  scl_tmo_sync #(.STAGES(scl_tmo_pkg::SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (scl_i),
    .q_o   (scl_s)
  );

  assign run = en_i && !scl_s;

  scl_tmo_prescale #(.CLKS_PER_MS(CLKS_PER_MS)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .tick_o(tick)
  );

  scl_tmo_timer #(.LIMIT_MS(LIMIT_MS)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .tick_i(tick),
    .ms_o  (low_ms_o),
    .sat_o (tmo_o),
    .hit_o (hit)
  );

  scl_tmo_status u_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (hit),
    .clr_i  (sts_clr_i),
    .abort_o(abort_o),
    .sts_o  (sts_o)
  );

  p_tmo_with_abort_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tmo_o) |-> abort_o);
  p_disable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !tmo_o && low_ms_o == '0);
  p_tmo_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_o && run |=> tmo_o);
endmodule

// File: tb/scl_low_tmo_mon_bench.sv
module scl_low_tmo_mon_bench;
  localparam int P   = 8;
  localparam int LIM = 25;
  localparam int DET = (LIM + 1) * P;
  localparam int MSW = $clog2(LIM + 2);

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b1, scl = 1'b1, clr = 1'b0;
  logic [MSW-1:0] low_ms;
  logic tmo, abort_p, sts;

  int cyc = 0, checks = 0, errors = 0;
  int exp_q[$];
  bit done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  scl_low_tmo_mon #(.CLKS_PER_MS(P), .LIMIT_MS(LIM)) u_scl_low_tmo_mon (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .scl_i(scl), .sts_clr_i(clr),
    .low_ms_o(low_ms), .tmo_o(tmo), .abort_o(abort_p), .sts_o(sts)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  task automatic at_cyc(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  // monitor: every abort must match the head of the expected queue (R2, R6, R10)
  always @(negedge clk) begin
    if (rst_n && abort_p && !done) begin
      if (exp_q.size() == 0) chk(1'b0, "R6 unexpected abort", cyc, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(cyc == e, "R2 abort cycle", cyc, e);
      end
    end
  end

  task automatic finish_run;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    int c, e;
    repeat (3) @(negedge clk);
    chk(low_ms == 0 && !tmo && !abort_p && !sts, "R1 reset state", {tmo, abort_p, sts}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11: just short of the limit
    c = cyc; scl = 1'b0;
    at_cyc(c + 2 + LIM * P);
    chk(int'(low_ms) == LIM, "R11 count reaches limit", int'(low_ms), LIM);
    at_cyc(c + DET - 1); scl = 1'b1;
    at_cyc(c + DET + 1);
    chk(!tmo && !sts, "R11 no timeout", {tmo, sts}, 0);
    at_cyc(c + DET + 4);
    chk(low_ms == 0, "R4 cleared after high", int'(low_ms), 0);

    // R2/R5/R6/R3: full timeout and saturation
    c = cyc; e = c + 2 + DET; exp_q.push_back(e); scl = 1'b0;
    at_cyc(e - 1);
    chk(!tmo && !sts, "R2 not before detection", {tmo, sts}, 0);
    at_cyc(e);
    chk(tmo && sts && int'(low_ms) == LIM + 1, "R2 detection", {tmo, sts}, 3);
    at_cyc(e + 15 * P);
    chk(tmo && int'(low_ms) == LIM + 1, "R3 saturated, R5 held", int'(low_ms), LIM + 1);

    // R4: release, fall at m+2 where m = c+1
    c = cyc; scl = 1'b1;
    at_cyc(c + 2);
    chk(tmo == 1'b1, "R4 tmo before clear", tmo, 1);
    at_cyc(c + 3);
    chk(!tmo && low_ms == 0, "R4 tmo cleared", tmo, 0);
    chk(sts == 1'b1, "R7 sticky after release", sts, 1);
    repeat (5) @(negedge clk);
    chk(sts == 1'b1, "R7 sticky holds", sts, 1);

    // R8: clear
    c = cyc; clr = 1'b1;
    at_cyc(c + 1); clr = 1'b0;
    chk(sts == 1'b0, "R8 clear", sts, 0);

    // R4: one-cycle glitch high restarts timing
    c = cyc; scl = 1'b0;
    at_cyc(c + 20 * P); scl = 1'b1;
    at_cyc(c + 20 * P + 1); scl = 1'b0;
    e = cyc + 2 + DET; exp_q.push_back(e);
    at_cyc(e - 1);
    chk(!tmo, "R4 restart after glitch", tmo, 0);
    at_cyc(e);
    chk(tmo && sts, "R4 detection after glitch", tmo, 1);
    c = cyc; scl = 1'b1;
    at_cyc(c + 4);
    c = cyc; clr = 1'b1;
    at_cyc(c + 1); clr = 1'b0;

    // R8: clear and set in the same cycle
    c = cyc; e = c + 2 + DET; exp_q.push_back(e); scl = 1'b0;
    at_cyc(e - 1);
    chk(sts == 1'b0, "R8 status clear before", sts, 0);
    clr = 1'b1;
    at_cyc(e); clr = 1'b0;
    chk(sts == 1'b1, "R8 set wins", sts, 1);
    at_cyc(e + 1);
    chk(sts == 1'b1, "R8 set wins held", sts, 1);
    c = cyc; scl = 1'b1;
    at_cyc(c + 4);
    c = cyc; clr = 1'b1;
    at_cyc(c + 1); clr = 1'b0;

    // R9: disabled, then R10: enable mid-low
    en = 1'b0;
    c = cyc; scl = 1'b0;
    at_cyc(c + DET + 5 * P);
    chk(!tmo && low_ms == 0 && !sts, "R9 disabled no count", int'(low_ms), 0);
    c = cyc; e = c + DET; exp_q.push_back(e); en = 1'b1;
    at_cyc(e - 1);
    chk(!tmo, "R10 not before", tmo, 0);
    at_cyc(e);
    chk(tmo && int'(low_ms) == LIM + 1, "R10 detection", int'(low_ms), LIM + 1);
    at_cyc(e + 3);
    c = cyc; en = 1'b0;
    chk(tmo == 1'b1, "R9 tmo before disable edge", tmo, 1);
    at_cyc(c + 1);
    chk(!tmo && low_ms == 0, "R9 tmo cleared on disable", tmo, 0);
    chk(sts == 1'b1, "R7 status survives disable", sts, 1);
    scl = 1'b1; en = 1'b1;
    repeat (6) @(negedge clk);

    chk(exp_q.size() == 0, "R2 missing abort", exp_q.size(), 0);
    finish_run();
  end
endmodule